// File: doc/BRIEF.md
# Serial LED Controller Register and FIFO Front End

This block is the register-mapped side of a serial LED driver. Software programs the frame set-up (enable, colour order, pixel count, bit and reset timing), then feeds 32-bit pixel words through a single data register. The words go into a transmit FIFO, which hands them to a downstream waveform encoder over a valid/ready pair. The encoder itself is outside this block. It reads the timing and frame fields from the configuration outputs and returns a one-cycle pulse when a frame ends.

While a frame runs, the block watches the FIFO fill level against a programmable trigger. When the level falls to the trigger or below, it either raises a DMA request line (DMA mode) or sets a sticky CPU-request status flag (CPU mode). Status flags are cleared by writing ones to them. One interrupt line combines them through per-source enables and a global enable. The fill level can be read live from the status register.

Top module: `ledtx_front`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, and `irq`, `dma_req` and `px_valid` are low.
- R2: Only the defined fields are stored and read back. All other bits read zero. Control (0x00): enable bit 0, colour order 8:6, pixel count 28:16. Bit timing (0x04): 26:21, 20:16, 10:6, 5:0. Reset timing (0x0C): 28:16, 9:0. DMA control (0x18): DMA enable bit 5, trigger 4:0. Interrupt control (0x1C): global enable bit 5, CPU-request enable bit 1, frame-done enable bit 0. The fields also drive the `cfg_*` outputs.
- R3: Each write to the data register (0x14) pushes one word. Words leave on `px_data` in write order while `px_valid` is high. Status bits 15:10 show the fill level.
- R4: The FIFO holds 32 words. A data write while it is full is dropped, and the level stays at 32.
- R5: A read of the data register returns zero.
- R6: A `frame_done` pulse sets status bit 0 and clears the control enable bit on the next edge. This happens even if a control write in the same cycle sets the enable bit.
- R7: Writing 1 to a status bit (0x20) clears it, and writing 0 leaves it. If a set event and a clearing write fall in the same cycle, the bit stays set.
- R8: With DMA disabled, the enable bit set and the fill level at or below the trigger, status bit 1 is set on the next edge. It is not set when the level is above the trigger.
- R9: With DMA enabled, `dma_req` is high exactly while the enable bit is set and the level is at or below the trigger. Status bit 1 is then not set.
- R10: `irq` is high when the global enable is set and at least one status bit is set together with its own enable.
- R11: A data push and an encoder pop in the same cycle leave the fill level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| px_valid | output | 1 | FIFO holds a word |
| px_data | output | 32 | Oldest FIFO word |
| px_ready | input | 1 | Encoder takes the word this cycle |
| frame_done | input | 1 | One-cycle end-of-frame pulse from the encoder |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | DMA request line |
| cfg_en | output | 1 | Frame enable |
| cfg_order | output | 3 | Colour-order code |
| cfg_len | output | 13 | Frame pixel count |
| cfg_bit_timing | output | 32 | Stored bit-timing register |
| cfg_reset_timing | output | 32 | Stored reset-timing register |

## Verification
Three kinds of event can land in the same clock cycle here.

- **Status set and clear.** A `frame_done` pulse can arrive in the cycle where software writes a one to clear status bit 0. The bench drives both strobes across one edge and expects the bit to read set afterwards.
- **Frame end and control write.** The same pulse can arrive with a control write that sets the enable. The bench expects the enable to read clear.
- **Push and pop.** A data push and an encoder pop can coincide. The bench expects the level to be unchanged and the word order to be preserved in the scoreboard.

// File: rtl/ledtx_pkg.sv
// Shared register offsets and field masks for the LED controller front end.
// Assumes byte offsets on a 6-bit register address.
package ledtx_pkg;
    localparam int unsigned REG_AW = 6;
    localparam int unsigned STS_W  = 2;

    localparam logic [REG_AW-1:0] A_CTRL = 6'h00;
    localparam logic [REG_AW-1:0] A_BITT = 6'h04;
    localparam logic [REG_AW-1:0] A_RSTT = 6'h0C;
    localparam logic [REG_AW-1:0] A_DATA = 6'h14;
    localparam logic [REG_AW-1:0] A_DMAC = 6'h18;
    localparam logic [REG_AW-1:0] A_INTC = 6'h1C;
    localparam logic [REG_AW-1:0] A_STAT = 6'h20;

    localparam logic [31:0] M_CTRL = 32'h1FFF_01C1;
    localparam logic [31:0] M_BITT = 32'h07FF_07FF;
    localparam logic [31:0] M_RSTT = 32'h1FFF_03FF;
    localparam logic [31:0] M_DMAC = 32'h0000_003F;
    localparam logic [31:0] M_INTC = 32'h0000_0023;
endpackage

// File: rtl/ledtx_fifo.sv
// Transmit FIFO with a live fill level.
// Assumes: a push while full is dropped, and a pop while empty is ignored.
// The storage has no reset; only pointers and level are reset.
module ledtx_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          push_ok, pop_ok;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem[rptr];

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    // Advance pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (pop_ok)  rptr <= step(rptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/ledtx_evt.sv
// Status flags, interrupt combine and DMA request.
// Bit 0 is frame done, bit 1 is CPU request. Set events win over a
// write-one-to-clear that arrives in the same cycle.
module ledtx_evt
    import ledtx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic             req_cond,
    input  logic             dma_en,
    input  logic [STS_W-1:0] clr,
    input  logic             gie,
    input  logic [STS_W-1:0] ie,
    output logic [STS_W-1:0] sts,
    output logic             irq,
    output logic             dma_req
);
    logic [STS_W-1:0] set_ev;

    assign set_ev  = {req_cond && !dma_en, frame_done};
    assign dma_req = req_cond && dma_en;
    assign irq     = gie && |(sts & ie);

    // Sticky status with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= set_ev | (sts & ~clr);
    end
endmodule

// File: rtl/ledtx_front.sv
// Register front end of the serial LED controller: configuration
// registers, data push into the transmit FIFO, request generation and
// interrupt status. Assumes single-cycle register writes and
// combinational reads.
module ledtx_front
    import ledtx_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              px_valid,
    output logic [31:0]       px_data,
    input  logic              px_ready,
    input  logic              frame_done,
    output logic              irq,
    output logic              dma_req,
    output logic              cfg_en,
    output logic [2:0]        cfg_order,
    output logic [12:0]       cfg_len,
    output logic [31:0]       cfg_bit_timing,
    output logic [31:0]       cfg_reset_timing
);
    logic [31:0]      ctrl_q, bitt_q, rstt_q, dmac_q, intc_q;
    logic [LVL_W-1:0] fill_lvl;
    logic             fifo_empty, fifo_full, wr_data, px_pop;
    logic             ctrl_en, dma_en, gie, req_cond;
    logic [STS_W-1:0] sts, sts_clr;
    logic             sts_done, sts_req;
    logic [5:0]       lvl_field;

    assign wr_data   = reg_wr && (reg_addr == A_DATA);
    assign px_pop    = px_valid && px_ready;
    assign px_valid  = !fifo_empty;
    assign ctrl_en   = ctrl_q[0];
    assign dma_en    = dmac_q[5];
    assign gie       = intc_q[5];
    assign req_cond  = ctrl_en && (fill_lvl <= LVL_W'(dmac_q[4:0]));
    assign sts_clr   = (reg_wr && reg_addr == A_STAT) ? reg_wdata[STS_W-1:0] : '0;
    assign sts_done  = sts[0];
    assign sts_req   = sts[1];
    assign lvl_field = 6'(fill_lvl);

    assign cfg_en           = ctrl_en;
    assign cfg_order        = ctrl_q[8:6];
    assign cfg_len          = ctrl_q[28:16];
    assign cfg_bit_timing   = bitt_q;
    assign cfg_reset_timing = rstt_q;

    // Configuration registers; frame end clears the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            bitt_q <= '0;
            rstt_q <= '0;
            dmac_q <= '0;
            intc_q <= '0;
        end else begin
            if (reg_wr) begin
                case (reg_addr)
                    A_CTRL:  ctrl_q <= reg_wdata & M_CTRL;
                    A_BITT:  bitt_q <= reg_wdata & M_BITT;
                    A_RSTT:  rstt_q <= reg_wdata & M_RSTT;
                    A_DMAC:  dmac_q <= reg_wdata & M_DMAC;
                    A_INTC:  intc_q <= reg_wdata & M_INTC;
                    default: ;
                endcase
            end
            if (frame_done) ctrl_q[0] <= 1'b0;
        end
    end

    // Read multiplexer; data register and unknown offsets read zero.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = ctrl_q;
            A_BITT:  reg_rdata = bitt_q;
            A_RSTT:  reg_rdata = rstt_q;
            A_DMAC:  reg_rdata = dmac_q;
            A_INTC:  reg_rdata = intc_q;
            A_STAT:  reg_rdata = {16'h0, lvl_field, 8'h0, sts};
            default: reg_rdata = '0;
        endcase
    end

    ledtx_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_data),
        .din   (reg_wdata),
        .pop   (px_pop),
        .dout  (px_data),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fill_lvl)
    );

    ledtx_evt u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .req_cond   (req_cond),
        .dma_en     (dma_en),
        .clr        (sts_clr),
        .gie        (gie),
        .ie         (intc_q[1:0]),
        .sts        (sts),
        .irq        (irq),
        .dma_req    (dma_req)
    );
endmodule

// File: rtl/ledtx_chk.sv
// Property checker for ledtx_front, attached by bind.
// Observes FIFO occupancy, status flags and request outputs.
module ledtx_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned LW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] level,
    input logic          full,
    input logic          push,
    input logic          pop,
    input logic          frame_done,
    input logic          sts_done,
    input logic          sts_req,
    input logic          ctrl_en,
    input logic          dma_en,
    input logic          gie,
    input logic          irq,
    input logic          dma_req
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> $stable(level)); // R4
    AST_PUSH_POP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full) |=> $stable(level)); // R11
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (sts_done && !ctrl_en)); // R6
    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> (ctrl_en && dma_en)); // R9
    AST_REQ_FLAG_CPU_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_req) |-> !$past(dma_en)); // R8
    AST_IRQ_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> !irq); // R10
endmodule

bind ledtx_front ledtx_chk #(.DEPTH(DEPTH), .LW(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (fill_lvl),
    .full       (fifo_full),
    .push       (wr_data),
    .pop        (px_pop),
    .frame_done (frame_done),
    .sts_done   (sts_done),
    .sts_req    (sts_req),
    .ctrl_en    (ctrl_en),
    .dma_en     (dma_en),
    .gie        (gie),
    .irq        (irq),
    .dma_req    (dma_req)
);

// File: tb/sim_ledtx_front.sv
// Scoreboard bench: pushed words enter a queue and a monitor compares
// each word the encoder side takes.
module sim_ledtx_front;
    import ledtx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        px_valid, px_ready = 1'b0;
    logic [31:0] px_data;
    logic        frame_done = 1'b0;
    logic        irq, dma_req, cfg_en;
    logic [2:0]  cfg_order;
    logic [12:0] cfg_len;
    logic [31:0] cfg_bit_timing, cfg_reset_timing;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q [$];
    logic [31:0] rv;

    always #2 clk = ~clk;

    ledtx_front u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push_px(input logic [31:0] d, input bit accepted);
        wr(A_DATA, d);
        if (accepted) exp_q.push_back(d);
    endtask

    task automatic drain();
        @(negedge clk); px_ready = 1'b1;
        repeat (40) @(negedge clk);
        px_ready = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Monitor: compare each word taken by the encoder side (R3).
    always @(posedge clk) begin
        if (rst_n && px_valid && px_ready) begin
            if (exp_q.size() == 0) check("R3 unexpected word", px_data, 32'hDEAD_0000);
            else check("R3 word order", px_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(A_STAT, rv); check("R1 status", rv, 0);
        rd(A_CTRL, rv); check("R1 ctrl", rv, 0);
        check("R1 irq/dma/valid", {29'b0, irq, dma_req, px_valid}, 0);

        // R2: field masking and readback
        wr(A_CTRL, 32'hFFFF_FFFE);
        rd(A_CTRL, rv); check("R2 ctrl", rv, 32'h1FFF_01C0);
        check("R2 cfg_len/order", {16'b0, cfg_len, cfg_order}, {16'b0, 13'h1FFF, 3'h7});
        wr(A_BITT, 32'hFFFF_FFFF);
        rd(A_BITT, rv); check("R2 bit timing", rv, 32'h07FF_07FF);
        wr(A_RSTT, 32'hFFFF_FFFF);
        rd(A_RSTT, rv); check("R2 reset timing", rv, 32'h1FFF_03FF);
        wr(A_DMAC, 32'hFFFF_FFFF);
        rd(A_DMAC, rv); check("R2 dma ctrl", rv, 32'h3F);
        wr(A_INTC, 32'hFFFF_FFFF);
        rd(A_INTC, rv); check("R2 int ctrl", rv, 32'h23);
        wr(A_DMAC, 0); wr(A_INTC, 0); wr(A_CTRL, 0);
        wr(A_STAT, 32'h3);

        // R3: push three words, level visible, in-order drain
        push_px(32'hA1, 1); push_px(32'hA2, 1); push_px(32'hA3, 1);
        rd(A_STAT, rv); check("R3 level 3", rv, 32'h0C00);
        check("R3 head word", px_data, 32'hA1);
        rd(A_DATA, rv); check("R5 data reads zero", rv, 0);
        drain();
        check("R3 queue drained", exp_q.size(), 0);
        check("R3 valid low when empty", {31'b0, px_valid}, 0);

        // R4: 33 writes, last dropped
        for (int i = 0; i < 33; i++) push_px(32'hB000 + i, i < 32);
        rd(A_STAT, rv); check("R4 level 32", rv, 32'h8000);
        drain();
        check("R4 drop left no extra word", exp_q.size(), 0);

        // R11: push and pop in one cycle
        push_px(32'hC1, 1); push_px(32'hC2, 1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = 32'hC3; px_ready = 1'b1;
        exp_q.push_back(32'hC3);
        @(negedge clk);
        reg_wr = 1'b0; px_ready = 1'b0;
        rd(A_STAT, rv); check("R11 level unchanged", rv, 32'h0800);
        drain();

        // R8: CPU request with trigger 0, empty FIFO
        wr(A_DMAC, 0);
        wr(A_CTRL, 1);
        @(negedge clk);
        rd(A_STAT, rv); check("R8 request flag set", rv, 32'h2);
        wr(A_STAT, 32'h2);
        rd(A_STAT, rv); check("R7 set wins over clear", rv, 32'h2);
        push_px(32'hD1, 1); push_px(32'hD2, 1);
        wr(A_STAT, 32'h2);
        @(negedge clk);
        rd(A_STAT, rv); check("R8 no flag above trigger", rv, 32'h0800);
        wr(A_DMAC, 3);
        @(negedge clk);
        rd(A_STAT, rv); check("R8 flag at trigger 3", rv, 32'h0802);

        // R10: interrupt combine
        wr(A_INTC, 32'h02);
        check("R10 no global enable", {31'b0, irq}, 0);
        wr(A_INTC, 32'h22);
        check("R10 irq on request", {31'b0, irq}, 1);
        wr(A_INTC, 32'h20);
        check("R10 source disabled", {31'b0, irq}, 0);
        wr(A_INTC, 0);

        // R9: DMA mode
        wr(A_DMAC, 32'h23);
        wr(A_STAT, 32'h2);
        @(negedge clk);
        check("R9 dma_req high", {31'b0, dma_req}, 1);
        rd(A_STAT, rv); check("R9 no CPU flag", rv, 32'h0800);
        wr(A_CTRL, 0);
        check("R9 dma_req drops with enable", {31'b0, dma_req}, 0);
        drain();
        wr(A_DMAC, 0);

        // R6: frame end
        wr(A_INTC, 32'h21);
        wr(A_CTRL, 1);
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
        rd(A_CTRL, rv); check("R6 enable cleared", rv, 0);
        rd(A_STAT, rv); check("R6 done flag", rv & 1, 1);
        check("R10 irq on done", {31'b0, irq}, 1);
        wr(A_STAT, 0);
        rd(A_STAT, rv); check("R7 zero write keeps", rv & 1, 1);
        wr(A_STAT, 32'h3);
        rd(A_STAT, rv); check("R7 one write clears", rv, 0);
        check("R10 irq cleared", {31'b0, irq}, 0);

        // R6: done against a control write in the same cycle
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = 1; frame_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_done = 1'b0;
        check("R6 done beats enable write", {31'b0, cfg_en}, 0);

        // R7: done pulse against a clearing write
        wr(A_STAT, 32'h3);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 1; frame_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; frame_done = 1'b0;
        rd(A_STAT, rv); check("R7 done set wins", rv & 1, 1);

        summary();
        $finish;
    end
endmodule